// File: doc/BRIEF.md
# Byte-rotating cache line store with phase-based wear levelling

This block holds the data array of a small first-level data cache model and spreads write stress across the cells of each line. Each line is 512 bits, handled as sixteen independent 32-bit words. On a write, the four bytes of every word are rotated by the current shift value. A global 2-bit counter supplies that value and advances once per phase, so over four phases every byte lane of a word takes every byte position. On a read, the bytes are rotated back, and the caller sees the data exactly as it was written. Tag lookup, way selection and replacement are handled outside.

Each line has one flag. A write sets the flag. It means "stored with the current shift". A clear flag means "stored with the previous shift". A small controller walks the phase through three named states. RUN counts ordinary cycles. SWEEP occupies the last `LINES` cycles before the boundary. In SWEEP it visits one line per cycle and moves every line whose flag is still clear forward by one rotation step, then sets that line's flag. ADVANCE is the single boundary cycle. In ADVANCE the shift value steps by one and all flags clear. The transitions are RUN→SWEEP (timer reaches the sweep start), SWEEP→ADVANCE (last line visited) and ADVANCE→RUN (always). Because of the sweep, a line that is never rewritten still decodes correctly after any number of phases.

A read returns data one cycle after it is requested. A write and a read in the same cycle are both accepted.

Top module: `bwl_line_store`

## Requirements
- R1: After reset, `rd_valid` is 0, `shift` is 0, and every line reads back as all zeros.
- R2: A write stores each word so that stored byte i (byte 0 = bits 7:0, byte 3 = bits 31:24) equals written byte (i+k) mod 4. Here k is the current shift, or the current shift plus one when the write falls in the ADVANCE cycle.
- R3: A read of a line written in the current phase returns the written data unchanged.
- R4: `shift` starts at 0 and increases by one, modulo 4, every `PHASE_CYCLES` clock cycles after reset. It does not change at any other time.
- R5: A write sets the line's flag. In the ADVANCE cycle, every flag clears except the flag of a line written in that same cycle.
- R6: A line that has not been written for any number of phases still reads back its original data.
- R7: When a write and a read address the same line in the same cycle, the read returns the contents from before the write, and the write takes effect for later reads.
- R8: `rd_valid` is 1 in the cycle after a cycle with `rd_en`=1, and 0 otherwise. `rd_data` is valid while `rd_valid` is 1.
- R9: During SWEEP, a visited line with a clear flag is re-rotated by one step and its flag is set. A user write to the same line in that cycle takes precedence, and user writes made during SWEEP or ADVANCE read back correctly.
- R10: The sixteen words of a line are rotated independently of each other, so a line with a different value in every byte round-trips exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the line `wr_idx` |
| wr_idx | input | IDX_W | Line to write |
| wr_data | input | 512 | Line data in its original byte order |
| rd_en | input | 1 | Read the line `rd_idx` |
| rd_idx | input | IDX_W | Line to read |
| rd_valid | output | 1 | Read data is present this cycle |
| rd_data | output | 512 | Line data realigned to the original byte order |
| shift | output | 2 | Current rotation amount |

## Verification
Two functions can meet in one cycle.

The first pair is a user write and a user read of the same line. The bench provokes this pair directly and also through a long random stream. It judges the result against a behavioural array that is updated only after the expected read value has been captured, so the read must return the old line.

The second pair is a user write and the sweep step for the same line, or a user write landing exactly in the ADVANCE cycle. The bench aligns writes to these cycles using its own count of elapsed cycles. It then checks that the data decodes correctly several phases later.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
    localparam int WORD_W    = 32;
    localparam int WORD_B    = WORD_W / 8;
    localparam int SHIFT_W   = 2;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_SWEEP   = 2'd1,
        PH_ADVANCE = 2'd2
    } ph_state_e;
endpackage

// File: rtl/bwl_rot_sel.sv
// Shared byte-order selector for a whole line: one 4-to-1 choice per word.
// INVERSE=0 rotates for storage, INVERSE=1 realigns on the way out.
module bwl_rot_sel
    import bwl_pkg::*;
#(
    parameter int WORDS   = 16,
    parameter bit INVERSE = 1'b0,
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic [LINE_W-1:0]  line_i,
    input  logic [SHIFT_W-1:0] sel_i,
    output logic [LINE_W-1:0]  line_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_in;
        logic [WORD_W-1:0] cand [WORD_B];
        assign w_in = line_i[g*WORD_W +: WORD_W];

        for (genvar k = 0; k < WORD_B; k++) begin : g_cand
            for (genvar b = 0; b < WORD_B; b++) begin : g_byte
                localparam int SRC = INVERSE ? ((b + WORD_B - k) % WORD_B)
                                             : ((b + k) % WORD_B);
                assign cand[k][b*8 +: 8] = w_in[SRC*8 +: 8];
            end
        end

        always_comb begin
            unique case (sel_i)
                2'd0:    line_o[g*WORD_W +: WORD_W] = cand[0];
                2'd1:    line_o[g*WORD_W +: WORD_W] = cand[1];
                2'd2:    line_o[g*WORD_W +: WORD_W] = cand[2];
                default: line_o[g*WORD_W +: WORD_W] = cand[3];
            endcase
        end
    end
endmodule

// File: rtl/bwl_phase_ctrl.sv
// Phase timer and controller: RUN -> SWEEP -> ADVANCE -> RUN.
module bwl_phase_ctrl
    import bwl_pkg::*;
#(
    parameter int LINES        = 16,
    parameter int PHASE_CYCLES = 8_000_000,
    localparam int IDX_W       = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TMR_W       = $clog2(PHASE_CYCLES),
    localparam int SWEEP_START = PHASE_CYCLES - LINES - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [SHIFT_W-1:0] shift_o,
    output logic [SHIFT_W-1:0] shift_wr_o,
    output logic               sweep_en_o,
    output logic [IDX_W-1:0]   sweep_idx_o,
    output logic               advance_o
);
    ph_state_e          state_q, state_d;
    logic [TMR_W-1:0]   timer_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [IDX_W-1:0]   sidx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN:     if (timer_q == TMR_W'(SWEEP_START - 1)) state_d = PH_SWEEP;
            PH_SWEEP:   if (sidx_q == IDX_W'(LINES - 1))        state_d = PH_ADVANCE;
            PH_ADVANCE: state_d = PH_RUN;
            default:    state_d = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            shift_q <= '0;
            sidx_q  <= '0;
        end else begin
            timer_q <= (state_q == PH_ADVANCE) ? '0 : timer_q + 1'b1;
            if (state_q == PH_ADVANCE) shift_q <= shift_q + 1'b1;
            sidx_q  <= (state_q == PH_SWEEP) ? sidx_q + 1'b1 : '0;
        end
    end

    always_comb begin
        sweep_en_o  = (state_q == PH_SWEEP);
        advance_o   = (state_q == PH_ADVANCE);
        sweep_idx_o = sidx_q;
        shift_o     = shift_q;
        shift_wr_o  = advance_o ? shift_q + 1'b1 : shift_q;
    end

    // R4: boundary lands exactly at the end of the phase
    p_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ADVANCE) |-> (timer_q == TMR_W'(PHASE_CYCLES - 1)));
    // R4: shift steps by one at the boundary only
    p_shift_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ADVANCE) |=> (shift_q == $past(shift_q) + 2'd1));
    p_shift_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_ADVANCE) |=> $stable(shift_q));
endmodule

// File: rtl/bwl_line_array.sv
// Line storage with one "rewritten this phase" flag per line.
module bwl_line_array
    import bwl_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int LINES = 16,
    localparam int LINE_W = WORDS * WORD_W,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [LINE_W-1:0] wline_i,
    input  logic              sweep_en_i,
    input  logic [IDX_W-1:0]  sweep_idx_i,
    input  logic              advance_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [LINE_W-1:0] rline_o,
    output logic              rflag_o
);
    logic [LINE_W-1:0] mem [LINES];
    logic [LINES-1:0]  flag_q;
    logic [LINE_W-1:0] sweep_old, sweep_new;
    logic              sweep_hit;

    assign sweep_old = mem[sweep_idx_i];

    // One fixed step forward: pure wiring, no selector
    for (genvar g = 0; g < WORDS; g++) begin : g_step
        for (genvar b = 0; b < WORD_B; b++) begin : g_byte
            assign sweep_new[g*WORD_W + b*8 +: 8] =
                sweep_old[g*WORD_W + ((b + 1) % WORD_B)*8 +: 8];
        end
    end

    assign sweep_hit = sweep_en_i && !flag_q[sweep_idx_i]
                       && !(we_i && (widx_i == sweep_idx_i));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
            flag_q <= '0;
        end else begin
            if (sweep_hit) begin
                mem[sweep_idx_i]    <= sweep_new;
                flag_q[sweep_idx_i] <= 1'b1;
            end
            if (advance_i) flag_q <= '0;
            if (we_i) begin
                mem[widx_i]    <= wline_i;
                flag_q[widx_i] <= 1'b1;
            end
        end
    end

    assign rline_o = mem[ridx_i];
    assign rflag_o = flag_q[ridx_i];

    // R5: a write marks its line
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> flag_q[$past(widx_i)]);
    // R5: the boundary clears every flag when nothing is written there
    p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !we_i) |=> (flag_q == '0));
    // R9: a visited stale line is marked after its step
    p_sweep_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en_i && !flag_q[sweep_idx_i]) |=> flag_q[$past(sweep_idx_i)]);
    // R9: sweep and boundary never coincide
    p_sweep_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sweep_en_i && advance_i));
endmodule

// File: rtl/bwl_line_store.sv
module bwl_line_store
    import bwl_pkg::*;
#(
    parameter int WORDS        = 16,
    parameter int LINES        = 16,
    parameter int PHASE_CYCLES = 8_000_000,
    localparam int LINE_W      = WORDS * WORD_W,
    localparam int IDX_W       = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LINE_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [LINE_W-1:0]  rd_data,
    output logic [SHIFT_W-1:0] shift
);
    logic [SHIFT_W-1:0] shift_wr, rd_shift;
    logic               sweep_en, advance, rflag;
    logic [IDX_W-1:0]   sweep_idx;
    logic [LINE_W-1:0]  wline, rline, rline_aligned;

    bwl_phase_ctrl #(.LINES(LINES), .PHASE_CYCLES(PHASE_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .shift_o(shift), .shift_wr_o(shift_wr),
        .sweep_en_o(sweep_en), .sweep_idx_o(sweep_idx), .advance_o(advance)
    );

    bwl_rot_sel #(.WORDS(WORDS), .INVERSE(1'b0)) u_wsel (
        .line_i(wr_data), .sel_i(shift_wr), .line_o(wline)
    );

    bwl_line_array #(.WORDS(WORDS), .LINES(LINES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(wr_en), .widx_i(wr_idx), .wline_i(wline),
        .sweep_en_i(sweep_en), .sweep_idx_i(sweep_idx), .advance_i(advance),
        .ridx_i(rd_idx), .rline_o(rline), .rflag_o(rflag)
    );

    // Clear flag: the line still holds the previous phase's rotation
    assign rd_shift = rflag ? shift : shift - 2'd1;

    bwl_rot_sel #(.WORDS(WORDS), .INVERSE(1'b1)) u_rsel (
        .line_i(rline), .sel_i(rd_shift), .line_o(rline_aligned)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rline_aligned;
        end
    end

    // Independent view of the byte expected in stored lane 0 of word 0
    logic [7:0] wr_lane0;
    assign wr_lane0 = wr_data[{shift_wr, 3'b000} +: 8];

    // R2: stored byte 0 of word 0 comes from input byte k
    p_store_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (u_store.mem[$past(wr_idx)][7:0] == $past(wr_lane0)));
    // R8: read response timing
    p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: tb/sim_bwl_line_store.sv
module sim_bwl_line_store;
    localparam int WORDS  = 16;
    localparam int LINES  = 8;
    localparam int PH     = 64;
    localparam int LW     = WORDS * 32;
    localparam int IW     = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [IW-1:0] wr_idx = '0, rd_idx = '0;
    logic [LW-1:0] wr_data = '0;
    logic          rd_valid;
    logic [LW-1:0] rd_data;
    logic [1:0]    shift;

    int checks = 0, errors = 0;
    int cyc = 0;
    logic [LW-1:0] ref_mem [LINES];

    always #5 clk = ~clk;

    bwl_line_store #(.WORDS(WORDS), .LINES(LINES), .PHASE_CYCLES(PH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .shift(shift)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // R4: shift follows elapsed cycles, checked on every clock
    always @(negedge clk) if (rst_n) begin
        checks++;
        if (shift != 2'((cyc / PH) % 4)) begin
            errors++;
            $display("FAIL R4 shift at cycle %0d: got %0d exp %0d", cyc, shift, (cyc / PH) % 4);
        end
    end

    function automatic logic [LW-1:0] rnd_line();
        logic [LW-1:0] l;
        for (int w = 0; w < WORDS; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic logic [LW-1:0] tag_line(input int idx);
        logic [LW-1:0] l;
        for (int w = 0; w < WORDS; w++)
            for (int b = 0; b < 4; b++)
                l[w*32 + b*8 +: 8] = 8'((idx << 6) | (w << 2) | b);
        return l;
    endfunction

    // Caller is at a negedge; one access per clock
    task automatic op(input bit we, input int wi, input logic [LW-1:0] wd,
                      input bit re, input int ri, input string req);
        logic [LW-1:0] exp;
        wr_en = we; wr_idx = IW'(wi); wr_data = wd;
        rd_en = re; rd_idx = IW'(ri);
        exp = ref_mem[ri];
        if (we) ref_mem[wi] = wd;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        checks++;
        if (re) begin
            if (rd_valid !== 1'b1 || rd_data !== exp) begin
                errors++;
                $display("FAIL %s line %0d: valid=%0b got %h exp %h", req, ri, rd_valid, rd_data, exp);
            end
        end else if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 rd_valid without read: got %0b exp 0", rd_valid);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase_pos(input int pos);
        while ((cyc % PH) != pos) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || shift !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset outputs: valid=%0b shift=%0d exp 0/0", rd_valid, shift);
        end
        rst_n = 1'b1;
        // R1: every line reads as zero
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R1");
        // R3 R10: distinct byte in every position, written then read back
        for (int i = 0; i < LINES; i++) op(1, i, tag_line(i), 0, 0, "R3");
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R10");
        // R6: untouched across several phases
        idle(3 * PH + 17);
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R6");
        // R7: same-line write and read in one cycle
        op(1, 2, rnd_line(), 1, 2, "R7");
        op(0, 0, '0, 1, 2, "R7");
        // R9: writes inside the sweep window and in the boundary cycle
        wait_phase_pos(PH - LINES - 1);
        op(1, 0, rnd_line(), 0, 0, "R9");
        op(1, 5, rnd_line(), 1, 5, "R9");
        wait_phase_pos(PH - 1);
        op(1, 3, rnd_line(), 1, 3, "R9");
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R9");
        idle(2 * PH + 5);
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R6");
        // R3 R7 R9: random mixed traffic across many phases
        for (int n = 0; n < 3000; n++) begin
            bit we, re;
            we = ($urandom % 3) == 0;
            re = ($urandom % 2) == 0;
            op(we, $urandom % LINES, rnd_line(), re, $urandom % LINES, "R3");
        end
        idle(5 * PH);
        for (int i = 0; i < LINES; i++) op(0, 0, '0, 1, i, "R6");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule